// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

The block is a periodic down-counter for operating-system time slicing. Software programs a reload value and enables the counter. The counter then decrements by one on each selected tick. A selected tick is either every core clock cycle or each cycle on which an external single-cycle tick enable is high. When the count moves from 1 to 0, a sticky zero flag is set. When the counter is next ticked at 0, it reloads and keeps running, so one period is the reload value plus one ticks.

When interrupt requests are enabled, each 1-to-0 transition also produces a one-cycle request pulse on `tick_req`. The processor's exception logic takes this pulse and pends the tick exception.

Software reaches three words through a plain register port: control/status, reload and current value. Reading the control word clears the zero flag. Writing any value to the current-value word zeroes the count and clears the flag. That write never produces a request. The register port is a control path with no back-pressure: a write or read takes effect in the cycle it is presented, and the port has no handshake.

Top module: `tick_timer`

## Requirements
- R1: After reset, every readable word (control, reload, current, and the unused word index 3) reads 0, and `tick_req` is 0.
- R2: Register layout by word index on `reg_addr`:
  - 0 is control/status: bit 0 run enable, bit 1 request enable, bit 2 source select, bit 16 zero flag. The flag is read-only.
  - 1 is reload, in bits 23:0.
  - 2 is current count, in bits 23:0.
  - 3 is unused: it reads 0 and ignores writes.
  - All other bits read 0 and ignore writes.
  - `reg_rdata` is valid in the same cycle as `reg_rd`.
- R3: The count changes only on a selected tick. A selected tick needs run enable = 1, plus either source select = 1 (every core clock) or source select = 0 with `ext_tick` high. When there is no selected tick, the count holds.
- R4: A selected tick at count 0 loads the reload value. Otherwise a selected tick decrements the count. With a nonzero reload R, the flag events repeat every R+1 selected ticks.
- R5: A selected tick that takes the count from 1 to 0 sets the zero flag. A read of the control word returns the flag as it stood before the read and clears it at the next clock edge. If a set and a read-clear fall in the same cycle, the set wins.
- R6: A write of any value to the current word makes the count 0 and clears the zero flag. It takes precedence over a tick in the same cycle and never produces `tick_req`.
- R7: `tick_req` is high for exactly one cycle, the cycle after a 1-to-0 transition, and only if request enable was 1 at that transition.
- R8: With reload 0, a count of 0 stays 0 on every tick and the zero flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | External tick enable, one core-clock cycle wide |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the zero flag on a control read) |
| reg_addr | input | 2 | Word index: 0 control, 1 reload, 2 current, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the word index |
| tick_req | output | 1 | One-cycle tick exception request |

## Verification
The bench steps the counter with single `ext_tick` pulses so that every count value is known. It sends a control read in the same cycle as the 1-to-0 tick. A design that lets the read-clear win would lose that flag event, and the next read would show the flag clear.

The bench writes the current word in the same cycle as a tick from count 1. A design that lets the tick through would raise `tick_req` or set the flag. The bench also sets reload to 0. A design that treats 0-to-0 as a transition would raise the flag.

In core-clock mode, a monitor measures the spacing between request pulses. An off-by-one in the reload path would show up there as a period of R or R+2 instead of R+1.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int ADDR_W   = 2;
  localparam int FLAG_BIT = 16;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  // control word bit positions that software decodes
  localparam int RUN_BIT = 0;
  localparam int REQ_BIT = 1;
  localparam int SRC_BIT = 2;
endpackage

// File: rtl/tick_count_core.sv
module tick_count_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign zero_evt = tick && !clr && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (tick) begin
      if (cnt == '0)     cnt <= reload;
      else               cnt <= cnt - ONE;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
  // R4
  reload_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt == '0) |=> (cnt == $past(reload)));
  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt != '0) |=> (cnt == $past(cnt) - ONE));
  // R8
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0 && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic run_d,
  input  logic req_d,
  input  logic src_d,
  input  logic ctrl_rd,
  input  logic cnt_wr,
  input  logic zero_evt,
  input  logic ext_tick,
  output logic run_en,
  output logic req_en,
  output logic src_core,
  output logic flag,
  output logic tick,
  output logic tick_req
);
  assign tick = run_en && (src_core || ext_tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      req_en   <= 1'b0;
      src_core <= 1'b0;
    end else if (ctrl_wr) begin
      run_en   <= run_d;
      req_en   <= req_d;
      src_core <= src_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  flag <= 1'b0;
    else if (zero_evt)           flag <= 1'b1;
    else if (ctrl_rd || cnt_wr)  flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_req <= 1'b0;
    else        tick_req <= zero_evt && req_en;
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag);
  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !zero_evt) |=> !flag);
  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |=> !tick_req);
  // R7
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && req_en) |=> (tick_req && flag));
  // R3
  no_tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tick);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_req
);
  localparam int PAD_W = DATA_W - CNT_W;

  reg_sel_e         sel;
  logic             ctrl_wr, ctrl_rd, reload_wr, cnt_wr;
  logic [CNT_W-1:0] reload_q, cnt;
  logic             run_en, req_en, src_core, flag, tick, zero_evt;
  logic             unused_wdata;

  assign sel       = reg_sel_e'(reg_addr);
  assign ctrl_wr   = reg_wr && (sel == SEL_CTRL);
  assign ctrl_rd   = reg_rd && (sel == SEL_CTRL);
  assign reload_wr = reg_wr && (sel == SEL_RELOAD);
  assign cnt_wr    = reg_wr && (sel == SEL_COUNT);
  assign unused_wdata = &{1'b0, reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_wr) reload_q <= reg_wdata[CNT_W-1:0];
  end

  tick_ctrl_reg ctrl_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (ctrl_wr),
    .run_d    (reg_wdata[RUN_BIT]),
    .req_d    (reg_wdata[REQ_BIT]),
    .src_d    (reg_wdata[SRC_BIT]),
    .ctrl_rd  (ctrl_rd),
    .cnt_wr   (cnt_wr),
    .zero_evt (zero_evt),
    .ext_tick (ext_tick),
    .run_en   (run_en),
    .req_en   (req_en),
    .src_core (src_core),
    .flag     (flag),
    .tick     (tick),
    .tick_req (tick_req)
  );

  tick_count_core #(.CNT_W(CNT_W)) core_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr      (cnt_wr),
    .reload   (reload_q),
    .cnt      (cnt),
    .zero_evt (zero_evt)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        reg_rdata[RUN_BIT]  = run_en;
        reg_rdata[REQ_BIT]  = req_en;
        reg_rdata[SRC_BIT]  = src_core;
        reg_rdata[FLAG_BIT] = flag;
      end
      SEL_RELOAD: reg_rdata = {{PAD_W{1'b0}}, reload_q};
      SEL_COUNT:  reg_rdata = {{PAD_W{1'b0}}, cnt};
      default:    reg_rdata = '0;
    endcase
  end

  // R6
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == '0 && !flag && !tick_req));
  // R2
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_SPARE) |-> (reg_rdata == '0));
  // R2
  ctrl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CTRL) |-> (reg_rdata[FLAG_BIT-1:SRC_BIT+1] == '0));
  // R7
  req_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |-> flag);
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_req;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int cyc = 0;
  int last_pulse = -1;
  int exp_period = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick_req(tick_req)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare read data against the scoreboard and time the requests
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        failures++;
        $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata, e);
      end
    end
    if (rst_n && tick_req) begin
      pulses++;
      if (exp_period != 0 && last_pulse >= 0) begin
        checks++;
        if (cyc - last_pulse != exp_period) begin
          failures++;
          $display("FAIL R4 period actual=%0d expected=%0d", cyc - last_pulse, exp_period);
        end
      end
      last_pulse = cyc;
    end
  end

  // driver: one cycle per call, entered and left at posedge+1
  task automatic op(input bit wr, input bit rd, input logic [1:0] a,
                    input logic [31:0] d, input bit ext,
                    input logic [31:0] e, input string t);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; ext_tick = ext;
    if (rd) begin exp_q.push_back(e); tag_q.push_back(t); end
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_rd = 1'b0; ext_tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    op(1'b1, 1'b0, a, d, 1'b0, '0, "");
  endtask
  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    op(1'b0, 1'b1, a, '0, 1'b0, e, t);
  endtask
  task automatic tk();
    op(1'b0, 1'b0, 2'd0, '0, 1'b1, '0, "");
  endtask
  task automatic chk_pulses(input int e, input string t);
    op(1'b0, 1'b0, 2'd0, '0, 1'b0, '0, "");
    checks++;
    if (pulses != e) begin
      failures++;
      $display("FAIL %s pulses actual=%0d expected=%0d", t, pulses, e);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int p0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 reload");
    rd(2'd2, 32'h0, "R1 count");
    rd(2'd3, 32'h0, "R1 spare");
    chk_pulses(0, "R1 no request");
    // R2 layout and unused bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h00FF_FFFF, "R2 reload pad");
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0000_0007, "R2 ctrl pad");
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0000_0123);
    rd(2'd2, 32'h0, "R6 write zeroes count");
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, 32'h0, "R2 spare ignores writes");
    // external tick mode, requests on
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h3);
    op(1'b0, 1'b0, 2'd0, '0, 1'b0, '0, "");
    rd(2'd2, 32'd0, "R3 no tick no change");
    tk(); rd(2'd2, 32'd2, "R4 load at zero");
    tk(); rd(2'd2, 32'd1, "R3 decrement");
    rd(2'd0, 32'h3, "R5 flag clear before zero");
    op(1'b0, 1'b1, 2'd0, '0, 1'b1, 32'h3, "R5 read in zero cycle");
    rd(2'd0, 32'h0001_0003, "R5 set wins over read clear");
    chk_pulses(1, "R7 request on zero");
    rd(2'd0, 32'h3, "R5 read clears flag");
    rd(2'd2, 32'd0, "R4 count at zero");
    tk(); rd(2'd2, 32'd2, "R4 reload again");
    // R6 software clear with a coincident tick
    tk();
    op(1'b1, 1'b0, 2'd2, 32'h55, 1'b1, '0, "");
    rd(2'd2, 32'd0, "R6 clear beats tick");
    rd(2'd0, 32'h3, "R6 no flag from clear");
    chk_pulses(1, "R6 no request from clear");
    tk(); tk(); tk();
    chk_pulses(2, "R7 second request");
    wr(2'd2, 32'h0);
    rd(2'd0, 32'h3, "R6 count write clears flag");
    // R7 requests disabled
    wr(2'd0, 32'h1);
    tk(); tk(); tk();
    rd(2'd0, 32'h0001_0001, "R7 flag without request");
    chk_pulses(2, "R7 no request when disabled");
    // R8 reload zero
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h3);
    wr(2'd2, 32'h0);
    tk(); tk(); tk();
    rd(2'd2, 32'd0, "R8 stays at zero");
    rd(2'd0, 32'h3, "R8 no flag");
    chk_pulses(2, "R8 no request");
    // R4 core clock period
    wr(2'd1, 32'd4);
    p0 = pulses; last_pulse = -1; exp_period = 5;
    wr(2'd0, 32'h7);
    repeat (40) op(1'b0, 1'b0, 2'd0, '0, 1'b0, '0, "");
    exp_period = 0;
    wr(2'd0, 32'h4);
    checks++;
    if (pulses - p0 < 6) begin
      failures++;
      $display("FAIL R4 core pulses actual=%0d expected>=6", pulses - p0);
    end
    // R3 disabled count holds
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0);
    tk(); tk(); tk();
    rd(2'd2, 32'd0, "R3 disabled holds");
    summary();
    $finish;
  end
endmodule